// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block sets the row rhythm for a multiplexed dot-matrix LCD with up to 16 common electrodes and 40 segment columns. Each row period starts with a burst of 40 segment shift clocks, which move one row of pattern bits into an external segment shifter. A single line-latch pulse then follows. On that pulse the shifted row is transferred to the segment outputs, the active common moves to the next row, and the drive-polarity signal flips. Flipping polarity on every row gives the panel an AC drive waveform whose period is two row periods.

The number of rows scanned per frame is 8, 11 or 16. It is picked by a two-bit duty select that encodes a single 5x8 text line, a single 5x10 text line, or two 5x8 text lines. Commons beyond the active row count are never selected. A change to the duty select is taken up only at the end of a frame, so a frame never mixes two scan lengths. The surrounding logic uses the one-hot common vector to drive the common waveforms, and clocks its segment pattern source from the shift and latch outputs.

Top module: `lcd_com_scan`

## Requirements
- R1: While reset is low and in the first cycle after it, comActive is 0x0001 and shiftClk, lineLatch and altPol are 0. The first frame after reset scans 16 rows, whatever the value of dutySel.
- R2: Every row period is 82 clock cycles long. In steps 0 to 79 of a row period, shiftClk is high for one cycle on every even step, which gives exactly 40 single-cycle pulses per row.
- R3: lineLatch is high for exactly one cycle per row period, in step 80. This is two cycles after the last shiftClk pulse, and it never coincides with a shiftClk pulse.
- R4: comActive has exactly one bit set at all times. It changes only in the cycle in which lineLatch goes high, and in that cycle it moves from row k to row k+1.
- R5: The duty select encodes the rows per frame as 0 = 8 rows, 1 = 11 rows, 2 = 16 rows and 3 = 16 rows. After the last row of the frame, the row index wraps to 0 (comActive = 0x0001).
- R6: A common whose index is at or above the active row count is never selected. At 8 rows, bits 15 to 8 of comActive stay 0. At 11 rows, bits 15 to 11 stay 0.
- R7: dutySel is sampled only on the latch that wraps the row index to 0. A change at any other time has no effect on the current frame's length.
- R8: altPol inverts in every cycle in which lineLatch goes high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dutySel | input | 2 | Rows per frame: 0 = 8, 1 = 11, 2 or 3 = 16 |
| comActive | output | 16 | One-hot selected common (bit i = common i) |
| shiftClk | output | 1 | Segment shift clock, 40 pulses per row |
| lineLatch | output | 1 | Row latch pulse, one per row |
| altPol | output | 1 | Drive polarity, inverts on every row |

## Verification
On every cycle the assertions check several properties: the common vector stays one-hot, it moves only with the latch, polarity flips exactly with the latch, shift pulses last a single cycle and never overlap the latch, commons above the active row count stay idle, and the captured duty stays put except on the wrapping latch. Three things are left to the bench's arithmetic model: the exact placement of the 40 shift pulses and the latch inside the 82-cycle row, the row count that each duty code produces, and the one-frame deferral of a duty change made partway through a frame. The bench sweeps every duty code, with changes both at frame boundaries and in the middle of a frame, and includes a reset asserted partway through a row.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_ROWS8  = 2'd0,
    DUTY_ROWS11 = 2'd1,
    DUTY_ROWS16 = 2'd2,
    DUTY_ROWS16X = 2'd3
  } duty_e;

  // Strobes from the sequencing control to the row datapath
  typedef struct packed {
    logic shiftStb;
    logic latchStb;
  } scan_strobe_t;

  localparam int ROWS_SHORT = 8;
  localparam int ROWS_TALL  = 11;

  // Row count for a duty code; fullRows is the common count of the build
  function automatic int rowsFor(input duty_e d, input int fullRows);
    case (d)
      DUTY_ROWS8:  rowsFor = ROWS_SHORT;
      DUTY_ROWS11: rowsFor = ROWS_TALL;
      default:     rowsFor = fullRows;
    endcase
  endfunction

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEGS = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  output scan_strobe_t strobe
);

  // Two cycles per shift pulse (high, low), then two cycles for the latch slot
  localparam int SHIFT_END = 2 * NUM_SEGS;
  localparam int STEPS     = SHIFT_END + 2;
  localparam int STEP_W    = $clog2(STEPS);

  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt <= '0;
    end else if (stepCnt == STEP_W'(STEPS - 1)) begin
      stepCnt <= '0;
    end else begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.shiftStb = (stepCnt < STEP_W'(SHIFT_END)) && !stepCnt[0];
    strobe.latchStb = (stepCnt == STEP_W'(SHIFT_END));
  end

endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scan_strobe_t        strobe,
  input  logic [1:0]          dutySel,
  output logic [NUM_COMS-1:0] comActive,
  output logic                shiftClk,
  output logic                lineLatch,
  output logic                altPol,
  output logic [1:0]          dutyCur
);

  localparam int ROW_W = $clog2(NUM_COMS);

  logic [ROW_W-1:0] rowIdx;
  logic [ROW_W:0]   rowsNow;
  logic [ROW_W:0]   lastRow;
  logic             frameWrap;
  duty_e            dutyReg;

  assign rowsNow   = (ROW_W+1)'(rowsFor(dutyReg, NUM_COMS));
  assign lastRow   = rowsNow - 1'b1;
  assign frameWrap = (rowIdx == lastRow[ROW_W-1:0]);
  assign dutyCur   = dutyReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowIdx    <= '0;
      dutyReg   <= DUTY_ROWS16;
      altPol    <= 1'b0;
      shiftClk  <= 1'b0;
      lineLatch <= 1'b0;
    end else begin
      shiftClk  <= strobe.shiftStb;
      lineLatch <= strobe.latchStb;
      if (strobe.latchStb) begin
        altPol <= ~altPol;
        if (frameWrap) begin
          rowIdx  <= '0;
          dutyReg <= duty_e'(dutySel);
        end else begin
          rowIdx <= rowIdx + 1'b1;
        end
      end
    end
  end

  // One decoder per common; rows outside the active count stay deselected
  for (genvar i = 0; i < NUM_COMS; i++) begin : g_com
    assign comActive[i] = (rowIdx == ROW_W'(i)) && ((ROW_W+1)'(i) < rowsNow);
  end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS = 16,
  parameter int NUM_SEGS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          dutySel,
  output logic [NUM_COMS-1:0] comActive,
  output logic                shiftClk,
  output logic                lineLatch,
  output logic                altPol
);

  scan_strobe_t strobe;
  logic [1:0]   dutyCur;

  lcd_scan_ctrl #(.NUM_SEGS(NUM_SEGS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  lcd_scan_dp #(.NUM_COMS(NUM_COMS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .dutySel   (dutySel),
    .comActive (comActive),
    .shiftClk  (shiftClk),
    .lineLatch (lineLatch),
    .altPol    (altPol),
    .dutyCur   (dutyCur)
  );

endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_COMS-1:0] comActive,
  input logic                shiftClk,
  input logic                lineLatch,
  input logic                altPol,
  input logic [1:0]          dutyCur
);

  int rowsCur;
  assign rowsCur = rowsFor(duty_e'(dutyCur), NUM_COMS);

  a_r4_one_common: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(comActive) == 1);

  a_r4_com_moves_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !lineLatch |-> $stable(comActive));

  a_r8_alt_flips: assert property (@(posedge clk) disable iff (!rst_n)
    lineLatch |-> (altPol != $past(altPol)));

  a_r8_alt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lineLatch |-> $stable(altPol));

  a_r2_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
    shiftClk |=> !shiftClk);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(shiftClk && lineLatch));

  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    lineLatch |=> !lineLatch);

  a_r6_idle_commons: assert property (@(posedge clk) disable iff (!rst_n)
    (comActive >> rowsCur) == '0);

  a_r7_duty_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(lineLatch && comActive[0]) |-> $stable(dutyCur));

endmodule

bind lcd_com_scan lcd_com_scan_chk #(.NUM_COMS(NUM_COMS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .comActive (comActive),
  .shiftClk  (shiftClk),
  .lineLatch (lineLatch),
  .altPol    (altPol),
  .dutyCur   (dutyCur)
);

// File: tb/tb_lcd_com_scan.sv
`timescale 1ns/1ps
module tb_lcd_com_scan;

  localparam int COMS  = 16;
  localparam int SEGS  = 40;
  localparam int STEPS = 2 * SEGS + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      dutySel = 2'd0;
  logic [COMS-1:0] comActive;
  logic            shiftClk;
  logic            lineLatch;
  logic            altPol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lcd_com_scan #(.NUM_COMS(COMS), .NUM_SEGS(SEGS)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dutySel   (dutySel),
    .comActive (comActive),
    .shiftClk  (shiftClk),
    .lineLatch (lineLatch),
    .altPol    (altPol)
  );

  always #2.5 clk = ~clk;

  logic       rstAtEdge;
  logic [1:0] dutyAtEdge;
  always @(posedge clk) begin
    rstAtEdge  <= rst_n;
    dutyAtEdge <= dutySel;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rowsOf(input logic [1:0] d);
    return (d == 2'd0) ? 8 : (d == 2'd1) ? 11 : 16;
  endfunction

  // Bench model: cycles since reset, row, duty of the current frame, polarity
  int         cyc = 0;
  int         expRow = 0;
  logic [1:0] expDuty = 2'd2;
  logic       expAlt = 1'b0;

  always @(negedge clk) begin
    if (rstAtEdge !== 1'b1) begin
      cyc = 0; expRow = 0; expDuty = 2'd2; expAlt = 1'b0;
      check("R1 comActive", 32'(comActive), 32'h1);
      check("R1 shiftClk", 32'(shiftClk), 0);
      check("R1 lineLatch", 32'(lineLatch), 0);
      check("R1 altPol", 32'(altPol), 0);
    end else begin
      int p;
      logic shExp, laExp;
      cyc++;
      p = (cyc - 1) % STEPS;
      shExp = (p < 2 * SEGS) && (p % 2 == 0);
      laExp = (p == 2 * SEGS);
      if (laExp) begin
        expAlt = ~expAlt;
        if (expRow == rowsOf(expDuty) - 1) begin
          expRow = 0;
          expDuty = dutyAtEdge;   // R7: taken only on the wrapping latch
        end else begin
          expRow++;
        end
      end
      check("R2 shiftClk", 32'(shiftClk), 32'(shExp));
      check("R3 lineLatch", 32'(lineLatch), 32'(laExp));
      check("R4 R5 R6 R7 comActive", 32'(comActive), 32'(1) << expRow);
      check("R8 altPol", 32'(altPol), 32'(expAlt));
    end
  end

  task automatic runCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic setDuty(input logic [1:0] d);
    @(negedge clk); #1 dutySel = d;
  endtask

  initial begin
    rst_n = 1'b0;
    dutySel = 2'd0;
    runCycles(3);
    #1 rst_n = 1'b1;
    // R1: first frame is 16 rows even with dutySel=0; then 8-row frames (R5)
    runCycles(16 * STEPS + 3 * 8 * STEPS);
    // R7: change in mid-frame, takes effect next frame; 11 rows (R5, R6)
    runCycles(3 * STEPS + 17);
    setDuty(2'd1);
    runCycles(4 * 11 * STEPS);
    setDuty(2'd2);
    runCycles(2 * 16 * STEPS + 40);
    setDuty(2'd3);
    runCycles(2 * 16 * STEPS);
    setDuty(2'd0);
    runCycles(5 * STEPS + 31);
    // Reset in the middle of a row
    #1 rst_n = 1'b0;
    runCycles(3);
    #1 rst_n = 1'b1;
    runCycles(16 * STEPS + 8 * STEPS + 10);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired R1 actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule